// File: doc/BRIEF.md
# Scalar AES Round-Step Unit

This unit runs one byte-wide step of an AES round for a 32-bit core. Each instruction takes one byte of the second source operand, chosen by a 2-bit field in the instruction word. It passes that byte through the forward or the inverse AES substitution. It then either spreads the result over one MixColumns column or leaves it as a bare byte. The 32-bit contribution is rotated into the selected byte lane and XORed into the first source operand.

Software chains four such steps per output column, and sixteen per full round state, feeding each result back as the next first operand. Keys are handled by the same chain: the round-key word is the first operand of the first step. The unit decodes the instruction word itself and checks separate enable inputs for the encrypt pair and for the decrypt pair. Each instruction gives a registered result, a valid strobe and an illegal-instruction strobe one clock later.

Top module: `aes_step_unit`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, valid_o, illegal_o and result_o are all zero.
- R2: An instruction is recognised only when bits 6:0 are 0110011, bits 14:12 are 000, bits 29:28 are 10 and bit 25 is 1. Bit 27 selects decrypt (1) or encrypt (0), and bit 26 selects the mixing form (1) or the final-round form (0). Any other word produces neither valid_o nor illegal_o.
- R3: Bits 31:30 give a byte index k. The step reads rs2_i[8k+7:8k].
- R4: Encrypt steps substitute the byte through the standard AES forward S-box. Decrypt steps use the standard AES inverse S-box.
- R5: In the final-round forms, the contribution is the substituted byte s in bits 7:0, with bits 31:8 zero.
- R6: In the encrypt mixing form, the contribution from bit 31 down to bit 0 is {3·s, s, s, 2·s}, with products in GF(2^8) reduced by 0x11B.
- R7: In the decrypt mixing form, the contribution from bit 31 down to bit 0 is {0x0B·s, 0x0D·s, 0x09·s, 0x0E·s}.
- R8: result_o equals rs1_i XOR (contribution rotated left by 8k bits).
- R9: A recognised encrypt step with enc_en_i low, or a recognised decrypt step with dec_en_i low, raises illegal_o one cycle later, with valid_o low and result_o unchanged.
- R10: A recognised, enabled step presented with in_valid_i high raises valid_o exactly one cycle later. When in_valid_i is low, nothing is raised.
- R11: result_o changes only when valid_o is raised and otherwise holds its last value.
- R12: Sixteen chained encrypt mixing steps, starting from the round-key columns, produce a standard AES middle round (SubBytes, ShiftRows, MixColumns, AddRoundKey).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction word and operands are valid |
| instr_i | input | 32 | Instruction word |
| rs1_i | input | 32 | Accumulator operand |
| rs2_i | input | 32 | Operand holding the byte to substitute |
| enc_en_i | input | 1 | Encrypt steps allowed |
| dec_en_i | input | 1 | Decrypt steps allowed |
| result_o | output | 32 | Registered step result |
| valid_o | output | 1 | Result produced this cycle |
| illegal_o | output | 1 | Recognised step was disabled |

## Verification
The assertions check on every cycle that valid_o and illegal_o never appear together and never without an input strobe one cycle earlier. They also check that an accepted step always yields valid_o, that result_o holds whenever valid_o is low, and that the final-round forms never set bits above the low byte. The substitution values, the GF(2^8) column products, the lane rotation and the decode of neighbouring codes can only be shown by the bench. It compares every byte value, every lane and every variant against an independent model. It also rebuilds a full AES round from sixteen chained steps and checks that round against known values.

// File: rtl/aes_step_pkg.sv
package aes_step_pkg;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // product with a constant of at most four bits
  function automatic logic [7:0] gf_mul_c(input logic [7:0] a, input logic [3:0] c);
    logic [7:0] acc, p;
    acc = '0;
    p   = a;
    for (int i = 0; i < 4; i++) begin
      if (c[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, p;
    acc = '0;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // a^254; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, p;
    r = 8'h01;
    p = a;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] affine_fwd(input logic [7:0] b);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] affine_inv(input logic [7:0] s);
    return rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
  endfunction

endpackage

// File: rtl/aes_step_decode.sv
module aes_step_decode (
  input  logic [31:0] instr_i,
  input  logic        enc_en_i,
  input  logic        dec_en_i,
  output logic        hit_o,
  output logic        allow_o,
  output logic        enc_o,
  output logic        mix_o,
  output logic [1:0]  bsel_o
);
  localparam logic [6:0] OPC_ARITH = 7'b0110011;

  logic unused_fields;
  assign unused_fields = ^{instr_i[24:15], instr_i[11:7]};

  assign hit_o   = (instr_i[6:0] == OPC_ARITH) && (instr_i[14:12] == 3'b000) &&
                   (instr_i[29:28] == 2'b10) && instr_i[25];
  assign enc_o   = ~instr_i[27];
  assign mix_o   = instr_i[26];
  assign bsel_o  = instr_i[31:30];
  assign allow_o = enc_o ? enc_en_i : dec_en_i;
endmodule

// File: rtl/aes_step_sbox.sv
module aes_step_sbox
  import aes_step_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  generate
    if (INV) begin : g_inv
      assign byte_o = gf_inv(affine_inv(byte_i));
    end else begin : g_fwd
      assign byte_o = affine_fwd(gf_inv(byte_i));
    end
  endgenerate
endmodule

// File: rtl/aes_step_mix.sv
module aes_step_mix
  import aes_step_pkg::*;
(
  input  logic [7:0]  s_i,
  input  logic        enc_i,
  input  logic        mix_i,
  output logic [31:0] col_o
);
  always_comb begin
    if (!mix_i)
      col_o = {24'h0, s_i};
    else if (enc_i)
      col_o = {gf_mul_c(s_i, 4'h3), s_i, s_i, gf_mul_c(s_i, 4'h2)};
    else
      col_o = {gf_mul_c(s_i, 4'hb), gf_mul_c(s_i, 4'hd),
               gf_mul_c(s_i, 4'h9), gf_mul_c(s_i, 4'he)};
  end
endmodule

// File: rtl/aes_step_unit.sv
module aes_step_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic            enc_en_i,
  input  logic            dec_en_i,
  output logic [XLEN-1:0] result_o,
  output logic            valid_o,
  output logic            illegal_o
);
  localparam int NLANE = XLEN / 8;

  logic       hit, allow, enc, mix;
  logic [1:0] bsel;
  logic [7:0] sel_byte, sb_fwd, sb_inv, sb;
  logic [XLEN-1:0] col, rot;
  logic [XLEN-1:0] rot_lane [NLANE];
  logic accept, reject;

  aes_step_decode u_dec (
    .instr_i(instr_i), .enc_en_i(enc_en_i), .dec_en_i(dec_en_i),
    .hit_o(hit), .allow_o(allow), .enc_o(enc), .mix_o(mix), .bsel_o(bsel)
  );

  assign sel_byte = rs2_i[8*bsel +: 8];

  aes_step_sbox #(.INV(1'b0)) u_sbox_fwd (.byte_i(sel_byte), .byte_o(sb_fwd));
  aes_step_sbox #(.INV(1'b1)) u_sbox_inv (.byte_i(sel_byte), .byte_o(sb_inv));
  assign sb = enc ? sb_fwd : sb_inv;

  aes_step_mix u_mix (.s_i(sb), .enc_i(enc), .mix_i(mix), .col_o(col));

  generate
    for (genvar k = 0; k < NLANE; k++) begin : g_rot
      if (k == 0) begin : g_id
        assign rot_lane[k] = col;
      end else begin : g_sh
        assign rot_lane[k] = {col[XLEN-1-8*k:0], col[XLEN-1:XLEN-8*k]};
      end
    end
  endgenerate
  assign rot = rot_lane[bsel];

  assign accept = in_valid_i && hit && allow;
  assign reject = in_valid_i && hit && !allow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o   <= accept;
      illegal_o <= reject;
      if (accept) result_o <= rs1_i ^ rot;
    end
  end

  // R5: final forms touch the low byte only
  always_comb begin
    if (accept && !mix) a_r5_final_narrow: assert (col[XLEN-1:8] == '0);
  end

  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && illegal_o));
  a_r9_illegal_from_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(in_valid_i));
  a_r10_valid_from_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(in_valid_i));
  a_r10_accept_gives_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && hit && allow) |=> valid_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
endmodule

// File: tb/tb_aes_step_unit.sv
`timescale 1ns/1ps
module tb_aes_step_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] instr_i = '0, rs1_i = '0, rs2_i = '0;
  logic        enc_en_i = 1'b1, dec_en_i = 1'b1;
  logic [31:0] result_o;
  logic        valid_o, illegal_o;

  always #2 clk_i = ~clk_i;

  aes_step_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .instr_i(instr_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .enc_en_i(enc_en_i), .dec_en_i(dec_en_i),
    .result_o(result_o), .valid_o(valid_o), .illegal_o(illegal_o)
  );

  typedef struct { bit v; bit il; logic [31:0] r; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  logic [31:0] held = '0;
  logic [7:0] fsb [256];
  logic [7:0] isb [256];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] x = a, y = b, p = 0;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  // S-box tables built by walking the multiplicative group with generator 3
  initial begin
    logic [7:0] p = 1, qv = 1;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      qv = qv ^ (qv << 1);
      qv = qv ^ (qv << 2);
      qv = qv ^ (qv << 4);
      if (qv[7]) qv = qv ^ 8'h09;
      fsb[p] = qv ^ rl8(qv, 1) ^ rl8(qv, 2) ^ rl8(qv, 3) ^ rl8(qv, 4) ^ 8'h63;
    end while (p != 1);
    fsb[0] = 8'h63;
    for (int i = 0; i < 256; i++) isb[fsb[i]] = i[7:0];
  end

  // dec: bit 27, mix: bit 26 (R2)
  function automatic logic [31:0] mk(input bit dec, input bit mix, input logic [1:0] bs);
    return {bs, 1'b1, 1'b0, dec, mix, 1'b1, 5'd7, 5'd6, 3'b000, 5'd5, 7'b0110011};
  endfunction

  function automatic logic [31:0] ref_res(input bit dec, input bit mix, input logic [1:0] bs,
                                          input logic [31:0] a, input logic [31:0] b);
    logic [7:0] s;
    logic [31:0] c;
    int sh;
    sh = 8 * bs;
    s = dec ? isb[8'(b >> sh)] : fsb[8'(b >> sh)];
    if (!mix) c = {24'h0, s};
    else if (!dec) c = {gm(s, 8'h03), s, s, gm(s, 8'h02)};
    else c = {gm(s, 8'h0b), gm(s, 8'h0d), gm(s, 8'h09), gm(s, 8'h0e)};
    return a ^ ((c << sh) | (c >> (32 - sh)));
  endfunction

  task automatic step(input bit v, input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                      input bit ee, input bit de, input string tag);
    exp_t e;
    bit hit, allowed;
    @(negedge clk_i);
    in_valid_i = v; instr_i = ins; rs1_i = a; rs2_i = b; enc_en_i = ee; dec_en_i = de;
    hit = (ins[6:0] == 7'b0110011) && (ins[14:12] == 3'b000) && (ins[29:28] == 2'b10) && ins[25];
    allowed = ins[27] ? de : ee;
    e.v = v && hit && allowed;
    e.il = v && hit && !allowed;
    if (e.v) held = ref_res(ins[27], ins[26], ins[31:30], a, b);
    e.r = held;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: one expectation per cycle, one cycle after it was driven
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(valid_o == e.v, {e.tag, " valid"}, {31'h0, valid_o}, {31'h0, e.v});
      chk(illegal_o == e.il, {e.tag, " illegal"}, {31'h0, illegal_o}, {31'h0, e.il});
      chk(result_o == e.r, {e.tag, " result"}, result_o, e.r);
    end
  end

  task automatic chain(input logic [31:0] a, input logic [31:0] b, input logic [1:0] bs,
                       output logic [31:0] r);
    step(1, mk(0, 1, bs), a, b, 1, 1, "R12 chain");
    @(posedge clk_i);
    #1;
    r = result_o;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] st [4];
    logic [31:0] rk [4];
    logic [31:0] ex [4];
    st = '{32'hbee33d19, 32'h2be2f4a0, 32'h2a8dc69a, 32'h0848f8e9};
    rk = '{32'h17fefaa0, 32'hb12c5488, 32'h3939a323, 32'h05766c2a};
    ex = '{32'hf27f9ca4, 32'h2b359f68, 32'h43ea5b6b, 32'h49506a02};

    // R1: reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk(valid_o == 0, "R1 valid in reset", {31'h0, valid_o}, 0);
    chk(illegal_o == 0, "R1 illegal in reset", {31'h0, illegal_o}, 0);
    chk(result_o == 0, "R1 result in reset", result_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, '0, '0, '0, 1, 1, "R1 after reset");

    // R3 R4 R5 R6 R7 R8: every variant and lane with varied operands
    for (int op = 0; op < 4; op++)
      for (int bs = 0; bs < 4; bs++)
        for (int n = 0; n < 6; n++)
          step(1, mk(op[1], op[0], bs[1:0]), $urandom, $urandom, 1, 1, "R3 R6 R7 R8 lanes");

    // R4 R5 R6 R7: every byte value through every variant, lane rotating
    for (int op = 0; op < 4; op++)
      for (int v = 0; v < 256; v++)
        step(1, mk(op[1], op[0], v[1:0]), 32'h0, {4{v[7:0]}}, 1, 1, "R4 R5 sbox sweep");

    // R2: near-miss words are ignored
    step(1, mk(0, 1, 1) ^ 32'h0000_0040, 32'hffff_ffff, 32'h1234_5678, 1, 1, "R2 bad opcode");
    step(1, mk(1, 0, 2) | 32'h0000_1000, 32'hffff_ffff, 32'h1234_5678, 1, 1, "R2 bad funct3");
    step(1, mk(0, 0, 0) & ~32'h0200_0000, 32'hffff_ffff, 32'h1234_5678, 1, 1, "R2 bit25 clear");
    step(1, mk(1, 1, 3) | 32'h1000_0000, 32'hffff_ffff, 32'h1234_5678, 1, 1, "R2 bit28 set");
    step(1, mk(0, 1, 0) & ~32'h2000_0000, 32'hffff_ffff, 32'h1234_5678, 1, 1, "R2 bit29 clear");

    // R10: strobe low
    step(0, mk(0, 1, 2), 32'h5555_aaaa, 32'h0102_0304, 1, 1, "R10 no strobe");
    step(1, mk(1, 1, 2), 32'h5555_aaaa, 32'h0102_0304, 1, 1, "R10 accepted");

    // R9: disabled extensions
    step(1, mk(0, 1, 1), 32'h1111_1111, 32'hdead_beef, 0, 1, "R9 enc disabled");
    step(1, mk(0, 0, 3), 32'h1111_1111, 32'hdead_beef, 0, 1, "R9 enc final disabled");
    step(1, mk(1, 0, 2), 32'h2222_2222, 32'hcafe_f00d, 1, 0, "R9 dec disabled");
    step(1, mk(1, 1, 0), 32'h2222_2222, 32'hcafe_f00d, 0, 1, "R9 dec with enc off");
    step(1, mk(0, 1, 0), 32'h3333_3333, 32'hcafe_f00d, 1, 0, "R9 enc with dec off");
    step(0, '0, '0, '0, 1, 1, "R11 idle");
    step(0, '0, '0, '0, 1, 1, "R11 idle");

    // R12: one full middle round from sixteen chained steps
    for (int j = 0; j < 4; j++) begin
      logic [31:0] acc;
      acc = rk[j];
      for (int r = 0; r < 4; r++) chain(acc, st[(j + r) % 4], r[1:0], acc);
      chk(acc == ex[j], "R12 round column", acc, ex[j]);
    end
    step(0, '0, '0, '0, 1, 1, "R11 idle");
    step(0, '0, '0, '0, 1, 1, "R11 idle");
    repeat (3) @(posedge clk_i);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule